// File: doc/BRIEF.md
# System Control Register Bank

This block is a byte-wide register bank on a simple synchronous I/O bus. It serves a platform's system control duties. It answers at one stand-alone control port (0x92) and in a window of 0x52 byte ports starting at 0x800. Inside the window it returns fixed board identity and equipment bytes. It also keeps a few control bits that software can write and read back.

Some writes drive level outputs: a reset request, a little-endian mode flag, a disk activity indicator and an I/O map mode. Other writes raise single-cycle requests: two lock-toggle pulses for separate protection regions and a cache-invalidate pulse. An access to an address inside the window that does not decode for its direction raises a one-cycle error strobe.

Every output is registered. Read data appears in the cycle after the read strobe and holds until the next read.

Top module: `sysio_regbank`

## Requirements
- R1: After reset, every output is 0: resetReq, leMode, diskLed, lockTog, cacheInv, mapMode, accErr and ioRdata. Reset also clears the stored 4-bit control value.
- R2: A write to port 0x92 sets resetReq to data bit 0 and leMode to data bit 1 from the next cycle on. A read of 0x92 returns leMode in bit 1 and zero in every other bit.
- R3: Reads return these fixed bytes: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03. A write to 0x800, 0x802 or 0x803 changes no output and raises no error.
- R4: A write to 0x808 sets diskLed to data bit 0.
- R5: A write to 0x81C stores data bits 3..0 as the control value. A read of 0x81C returns that value with bits 7..4 zero.
- R6: A write to 0x850 sets mapMode to data bit 0. A read of 0x850 returns mapMode in bit 0 and zero in bits 7..1.
- R7: A write to 0x810 drives lockTog[0] high for exactly one cycle, and a write to 0x812 does the same for lockTog[1], whatever the data.
- R8: A write to 0x814 drives cacheInv high for one cycle. A read of 0x814 returns 0xFF and raises no error.
- R9: A read in 0x800..0x851 at an address outside the read set of R3, R5, R6 and R8 returns 0xFF and pulses accErr for one cycle. A write in the window at an address outside the write set (0x800, 0x802, 0x803, 0x808, 0x810, 0x812, 0x814, 0x81C, 0x850) pulses accErr and changes no other output or stored value.
- R10: An access to an address that is neither 0x92 nor in 0x800..0x851 raises no error and changes no state. A read there returns 0x00.
- R11: ioRdata is loaded on the clock edge that samples ioRd. It holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | Port address |
| ioRd | input | 1 | Read strobe, one access per cycle |
| ioWr | input | 1 | Write strobe, one access per cycle |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Registered read data |
| resetReq | output | 1 | Reset request level |
| leMode | output | 1 | Little-endian mode flag |
| diskLed | output | 1 | Disk activity indicator |
| lockTog | output | 2 | Per-region lock-toggle pulses |
| cacheInv | output | 1 | Cache-invalidate pulse |
| mapMode | output | 1 | I/O map mode level |
| accErr | output | 1 | Undecoded-access error pulse |

## Verification
The assertions assume that ioRd and ioWr are never high in the same cycle. They also assume that both strobes and the address are driven to known values from the first clock edge, reset included, so every check of the previous cycle looks at defined inputs. The stimulus issues at most one access per operation and pulls both strobes low between operations. It draws addresses from the decoded ports, the window edges, random window offsets and random addresses outside the block. This mix reaches every read and write decode path, including the error paths.

// File: rtl/sysio_pkg.sv
package sysio_pkg;
  localparam int DATA_W   = 8;
  localparam int CTL_W    = 4;
  localparam int NUM_LOCK = 2;

  typedef enum logic [2:0] {
    RD_ZERO    = 3'd0,
    RD_ONES    = 3'd1,
    RD_SPECIAL = 3'd2,
    RD_CTL     = 3'd3,
    RD_MAP     = 3'd4,
    RD_CONST   = 3'd5
  } rdSel_e;

  typedef struct packed {
    logic                wrSpecial;
    logic                wrDisk;
    logic                wrCtl;
    logic                wrMap;
    logic                cacheInv;
    logic [NUM_LOCK-1:0] lockTog;
    logic                rdEn;
    rdSel_e              rdSel;
    logic [DATA_W-1:0]   constVal;
    logic                err;
  } ctlStrobe_t;
endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SPECIAL_PORT = 'h0092,
  parameter logic [ADDR_W-1:0] WIN_BASE     = 'h0800,
  parameter int                WIN_SIZE     = 'h52,
  parameter logic [ADDR_W-1:0] REG_CPU      = 'h0800,
  parameter logic [ADDR_W-1:0] REG_FEAT     = 'h0802,
  parameter logic [ADDR_W-1:0] REG_STAT     = 'h0803,
  parameter logic [ADDR_W-1:0] REG_DISK     = 'h0808,
  parameter logic [ADDR_W-1:0] REG_EQUIP    = 'h080C,
  parameter logic [ADDR_W-1:0] REG_XFEAT    = 'h0810,
  parameter logic [ADDR_W-1:0] LOCK_BASE    = 'h0810,
  parameter int                LOCK_STRIDE  = 2,
  parameter logic [ADDR_W-1:0] REG_INV      = 'h0814,
  parameter logic [ADDR_W-1:0] REG_KEY      = 'h0818,
  parameter logic [ADDR_W-1:0] REG_CTL      = 'h081C,
  parameter logic [ADDR_W-1:0] REG_CACHE    = 'h0823,
  parameter logic [ADDR_W-1:0] REG_MAP      = 'h0850,
  parameter logic [DATA_W-1:0] VAL_CPU      = 8'hEF,
  parameter logic [DATA_W-1:0] VAL_FEAT     = 8'hAD,
  parameter logic [DATA_W-1:0] VAL_STAT     = 8'hE0,
  parameter logic [DATA_W-1:0] VAL_EQUIP    = 8'h3C,
  parameter logic [DATA_W-1:0] VAL_XFEAT    = 8'h39,
  parameter logic [DATA_W-1:0] VAL_KEY      = 8'h00,
  parameter logic [DATA_W-1:0] VAL_CACHE    = 8'h03
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  output ctlStrobe_t        strobe
);
  localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + (ADDR_W+1)'(WIN_SIZE);

  logic                inWin;
  logic [NUM_LOCK-1:0] lockHit;

  assign inWin = ({1'b0, ioAddr} >= {1'b0, WIN_BASE}) && ({1'b0, ioAddr} < WIN_END);

  for (genvar g = 0; g < NUM_LOCK; g++) begin : gLock
    localparam logic [ADDR_W-1:0] LADDR = ADDR_W'(LOCK_BASE + ADDR_W'(g * LOCK_STRIDE));
    assign lockHit[g] = ioWr && (ioAddr == LADDR);
  end

  always_comb begin
    strobe         = '0;
    strobe.lockTog = lockHit;
    if (ioWr) begin
      if (ioAddr == SPECIAL_PORT) begin
        strobe.wrSpecial = 1'b1;
      end else if (inWin) begin
        case (ioAddr)
          REG_CPU, REG_FEAT, REG_STAT: ;
          REG_DISK: strobe.wrDisk   = 1'b1;
          REG_INV:  strobe.cacheInv = 1'b1;
          REG_CTL:  strobe.wrCtl    = 1'b1;
          REG_MAP:  strobe.wrMap    = 1'b1;
          default:  strobe.err      = ~(|lockHit);
        endcase
      end
    end else if (ioRd) begin
      strobe.rdEn = 1'b1;
      if (ioAddr == SPECIAL_PORT) begin
        strobe.rdSel = RD_SPECIAL;
      end else if (inWin) begin
        strobe.rdSel = RD_CONST;
        case (ioAddr)
          REG_CPU:   strobe.constVal = VAL_CPU;
          REG_FEAT:  strobe.constVal = VAL_FEAT;
          REG_STAT:  strobe.constVal = VAL_STAT;
          REG_EQUIP: strobe.constVal = VAL_EQUIP;
          REG_XFEAT: strobe.constVal = VAL_XFEAT;
          REG_KEY:   strobe.constVal = VAL_KEY;
          REG_CACHE: strobe.constVal = VAL_CACHE;
          REG_INV:   strobe.rdSel    = RD_ONES;
          REG_CTL:   strobe.rdSel    = RD_CTL;
          REG_MAP:   strobe.rdSel    = RD_MAP;
          default: begin
            strobe.rdSel = RD_ONES;
            strobe.err   = 1'b1;
          end
        endcase
      end else begin
        strobe.rdSel = RD_ZERO;
      end
    end
  end
endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
  import sysio_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   ioWdata,
  input  ctlStrobe_t          strobe,
  output logic [DATA_W-1:0]   ioRdata,
  output logic                resetReq,
  output logic                leMode,
  output logic                diskLed,
  output logic [NUM_LOCK-1:0] lockTog,
  output logic                cacheInv,
  output logic                mapMode,
  output logic                accErr
);
  logic [CTL_W-1:0]  ctlQ;
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    case (strobe.rdSel)
      RD_ONES:    rdNext = '1;
      RD_SPECIAL: rdNext = DATA_W'({leMode, 1'b0});
      RD_CTL:     rdNext = DATA_W'(ctlQ);
      RD_MAP:     rdNext = DATA_W'(mapMode);
      RD_CONST:   rdNext = strobe.constVal;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioRdata  <= '0;
      resetReq <= 1'b0;
      leMode   <= 1'b0;
      diskLed  <= 1'b0;
      ctlQ     <= '0;
      mapMode  <= 1'b0;
      lockTog  <= '0;
      cacheInv <= 1'b0;
      accErr   <= 1'b0;
    end else begin
      if (strobe.rdEn)      ioRdata  <= rdNext;
      if (strobe.wrSpecial) begin
        resetReq <= ioWdata[0];
        leMode   <= ioWdata[1];
      end
      if (strobe.wrDisk)    diskLed  <= ioWdata[0];
      if (strobe.wrCtl)     ctlQ     <= ioWdata[CTL_W-1:0];
      if (strobe.wrMap)     mapMode  <= ioWdata[0];
      lockTog  <= strobe.lockTog;
      cacheInv <= strobe.cacheInv;
      accErr   <= strobe.err;
    end
  end
endmodule

// File: rtl/sysio_regbank.sv
module sysio_regbank
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SPECIAL_PORT = 'h0092,
  parameter logic [ADDR_W-1:0] WIN_BASE     = 'h0800,
  parameter int                WIN_SIZE     = 'h52,
  parameter logic [ADDR_W-1:0] REG_DISK     = 'h0808,
  parameter logic [ADDR_W-1:0] LOCK_BASE    = 'h0810,
  parameter int                LOCK_STRIDE  = 2,
  parameter logic [ADDR_W-1:0] REG_INV      = 'h0814,
  parameter logic [ADDR_W-1:0] REG_MAP      = 'h0850
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   ioAddr,
  input  logic                ioRd,
  input  logic                ioWr,
  input  logic [DATA_W-1:0]   ioWdata,
  output logic [DATA_W-1:0]   ioRdata,
  output logic                resetReq,
  output logic                leMode,
  output logic                diskLed,
  output logic [NUM_LOCK-1:0] lockTog,
  output logic                cacheInv,
  output logic                mapMode,
  output logic                accErr
);
  localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + (ADDR_W+1)'(WIN_SIZE);

  ctlStrobe_t strobe;
  logic       inWinNow;

  assign inWinNow = ({1'b0, ioAddr} >= {1'b0, WIN_BASE}) && ({1'b0, ioAddr} < WIN_END);

  sysio_decode #(
    .ADDR_W(ADDR_W), .SPECIAL_PORT(SPECIAL_PORT), .WIN_BASE(WIN_BASE),
    .WIN_SIZE(WIN_SIZE), .REG_DISK(REG_DISK), .LOCK_BASE(LOCK_BASE),
    .LOCK_STRIDE(LOCK_STRIDE), .REG_INV(REG_INV), .REG_MAP(REG_MAP)
  ) uDecode (
    .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr), .strobe(strobe)
  );

  sysio_regs uRegs (
    .clk(clk), .rstN(rstN), .ioWdata(ioWdata), .strobe(strobe),
    .ioRdata(ioRdata), .resetReq(resetReq), .leMode(leMode),
    .diskLed(diskLed), .lockTog(lockTog), .cacheInv(cacheInv),
    .mapMode(mapMode), .accErr(accErr)
  );

  // R2: special port write sets reset request from bit 0
  a_r2_reset_req: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == SPECIAL_PORT) |=> (resetReq == $past(ioWdata[0])));

  // R2: endian flag moves only on a special port write
  a_r2_endian_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioWr && ioAddr == SPECIAL_PORT) |-> $stable(leMode));

  // R4: disk indicator moves only on its own write
  a_r4_disk_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioWr && ioAddr == REG_DISK) |-> $stable(diskLed));

  // R6: map mode follows bit 0 of its write and holds otherwise
  a_r6_map_set: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == REG_MAP) |=> (mapMode == $past(ioWdata[0])));
  a_r6_map_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioWr && ioAddr == REG_MAP) |-> $stable(mapMode));

  // R7: each lock pulse is caused by a write to its own port
  for (genvar g = 0; g < NUM_LOCK; g++) begin : gLockChk
    localparam logic [ADDR_W-1:0] LADDR = ADDR_W'(LOCK_BASE + ADDR_W'(g * LOCK_STRIDE));
    a_r7_lock_cause: assert property (@(posedge clk) disable iff (!rstN)
      lockTog[g] |-> $past(ioWr && ioAddr == LADDR));
  end

  // R8: cache invalidate only follows a write to its port
  a_r8_inv_cause: assert property (@(posedge clk) disable iff (!rstN)
    cacheInv |-> $past(ioWr && ioAddr == REG_INV));

  // R9: error strobe only follows an access inside the window
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past((ioWr || ioRd) && inWinNow));

  // R10: accesses outside the block never raise an error
  a_r10_outside_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(!inWinNow) |-> !accErr);

  // R11: read data holds without a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioRd) |-> $stable(ioRdata));

  // single strobe per cycle assumed at the bus
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd && ioWr));
endmodule

// File: tb/tb_sysio_regbank.sv
module tb_sysio_regbank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioRd = 1'b0;
  logic        ioWr = 1'b0;
  logic [7:0]  ioWdata = '0;
  logic [7:0]  ioRdata;
  logic        resetReq, leMode, diskLed, cacheInv, mapMode, accErr;
  logic [1:0]  lockTog;

  int nChk = 0;
  int nBad = 0;

  logic       mRst = 0, mLe = 0, mDisk = 0, mMap = 0;
  logic [3:0] mCtl = 0;

  always #4 clk = ~clk;

  sysio_regbank dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .resetReq(resetReq), .leMode(leMode),
    .diskLed(diskLed), .lockTog(lockTog), .cacheInv(cacheInv),
    .mapMode(mapMode), .accErr(accErr)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit inWin(input logic [15:0] a);
    return (a >= 16'h0800) && (a <= 16'h0851);
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a);
    case (a)
      16'h0092: return {6'b0, mLe, 1'b0};
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h0823: return 8'h03;
      16'h081C: return {4'b0, mCtl};
      16'h0850: return {7'b0, mMap};
      default:  return inWin(a) ? 8'hFF : 8'h00;
    endcase
  endfunction

  function automatic bit expErr(input logic [15:0] a, input bit wr);
    if (!inWin(a)) return 0;
    if (wr) begin
      case (a)
        16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h0810,
        16'h0812, 16'h0814, 16'h081C, 16'h0850: return 0;
        default: return 1;
      endcase
    end
    case (a)
      16'h0800, 16'h0802, 16'h0803, 16'h080C, 16'h0810, 16'h0818,
      16'h0823, 16'h0814, 16'h081C, 16'h0850: return 0;
      default: return 1;
    endcase
  endfunction

  task automatic checkState(input string tag);
    chk(tag, "resetReq", 16'(resetReq), 16'(mRst));
    chk(tag, "leMode",   16'(leMode),   16'(mLe));
    chk(tag, "diskLed",  16'(diskLed),  16'(mDisk));
    chk(tag, "mapMode",  16'(mapMode),  16'(mMap));
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d, input string tag);
    logic [1:0] expLock;
    @(negedge clk);
    ioAddr = a; ioWdata = d; ioWr = 1'b1; ioRd = 1'b0;
    @(posedge clk);
    #1;
    expLock = {a == 16'h0812, a == 16'h0810};
    if (a == 16'h0092) begin mRst = d[0]; mLe = d[1]; end
    if (a == 16'h0808) mDisk = d[0];
    if (a == 16'h081C) mCtl = d[3:0];
    if (a == 16'h0850) mMap = d[0];
    chk({tag, " R7"}, "lockTog", 16'(lockTog), 16'(expLock));
    chk({tag, " R8"}, "cacheInv", 16'(cacheInv), 16'(a == 16'h0814));
    chk({tag, " R9"}, "accErr", 16'(accErr), 16'(expErr(a, 1)));
    checkState(tag);
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic doRead(input logic [15:0] a, input string tag);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1; ioWr = 1'b0;
    @(posedge clk);
    #1;
    chk({tag, " R11"}, "ioRdata", 16'(ioRdata), 16'(expRead(a)));
    chk({tag, " R9"}, "accErr", 16'(accErr), 16'(expErr(a, 0)));
    chk({tag, " R7"}, "lockTog", 16'(lockTog), 16'h0);
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  function automatic logic [15:0] pickAddr();
    int k;
    logic [15:0] r;
    k = int'($urandom_range(0, 19));
    case (k)
      0:  return 16'h0092;
      1:  return 16'h0800;
      2:  return 16'h0802;
      3:  return 16'h0803;
      4:  return 16'h0808;
      5:  return 16'h080C;
      6:  return 16'h0810;
      7:  return 16'h0812;
      8:  return 16'h0814;
      9:  return 16'h0818;
      10: return 16'h081C;
      11: return 16'h0823;
      12: return 16'h0850;
      13: return 16'h0851;
      14: return 16'h07FF;
      15: return 16'h0852;
      16, 17: return 16'h0800 + 16'($urandom_range(0, 16'h51));
      default: begin
        r = 16'($urandom);
        if (r == 16'h0092 || inWin(r)) r = 16'h4000 ^ r;
        return r;
      end
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset values
    chk("R1", "ioRdata", 16'(ioRdata), 16'h0);
    chk("R1", "lockTog", 16'(lockTog), 16'h0);
    chk("R1", "cacheInv", 16'(cacheInv), 16'h0);
    chk("R1", "accErr", 16'(accErr), 16'h0);
    checkState("R1");
    doRead(16'h081C, "R1 ctl");

    // R2: special port
    doWrite(16'h0092, 8'h03, "R2");
    doRead(16'h0092, "R2");
    doWrite(16'h0092, 8'hFC, "R2");
    doRead(16'h0092, "R2");
    doWrite(16'h0092, 8'h02, "R2");
    doRead(16'h0092, "R2");

    // R3: identity bytes, read-only writes ignored
    doWrite(16'h0800, 8'h55, "R3");
    doWrite(16'h0802, 8'hFF, "R3");
    doWrite(16'h0803, 8'h00, "R3");
    doRead(16'h0800, "R3");
    doRead(16'h0802, "R3");
    doRead(16'h0803, "R3");
    doRead(16'h080C, "R3");
    doRead(16'h0810, "R3");
    doRead(16'h0818, "R3");
    doRead(16'h0823, "R3");

    // R4, R5, R6
    doWrite(16'h0808, 8'hFF, "R4");
    doWrite(16'h0808, 8'hFE, "R4");
    doWrite(16'h081C, 8'hA7, "R5");
    doRead(16'h081C, "R5");
    doWrite(16'h0850, 8'h01, "R6");
    doRead(16'h0850, "R6");

    // R7, R8
    doWrite(16'h0810, 8'h00, "R7");
    doWrite(16'h0812, 8'hA5, "R7");
    doWrite(16'h0814, 8'h12, "R8");
    doRead(16'h0814, "R8");

    // R9: undecoded in window, including edges and read-only equipment
    doWrite(16'h080C, 8'hFF, "R9");
    doWrite(16'h0851, 8'hFF, "R9");
    doWrite(16'h081D, 8'h0F, "R9");
    doRead(16'h081C, "R9 ctl");
    doRead(16'h0851, "R9");
    doRead(16'h0808, "R9");

    // R10: outside the block
    doRead(16'h0852, "R10");
    doRead(16'h07FF, "R10");
    doWrite(16'h0093, 8'h00, "R10");
    doWrite(16'h0C50, 8'h00, "R10");
    doRead(16'h0850, "R10 map");

    for (int i = 0; i < 800; i++) begin
      logic [15:0] a;
      a = pickAddr();
      if ($urandom_range(0, 1) == 1) doWrite(a, 8'($urandom), "rand");
      else doRead(a, "rand");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule